// File: doc/BRIEF.md
# Register-Mapped Single-Byte SPI Master

This block is a SPI master reached through two 32-bit registers on a simple synchronous bus. The word at offset 0x0 holds the control settings and reports status; the word at offset 0x4 holds one data byte. Software first places a byte in the data word. It then writes the control word with the start bit set. The block shifts that byte out, most significant bit first, and captures eight bits from the serial input at the same time. When the status flag drops, the captured byte can be read from the data word.

The same control word sets the levels of three select lines, a loopback switch and the serial clock divider. The select lines sit on the even bits 0, 2 and 4. The loopback switch is bit 3. The divider is a field that starts at bit 27. A field value N makes one serial clock period last 2·(N+1) reference cycles. A control write with the start bit clear only changes these settings.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, all three select lines are high, busy is 0, SCK and MOSI are low, and a read of the control word returns 0x00000015.
- R2: When idle, a control write with bit 1 set starts a transfer. Busy (control read bit 1) is 1 from the next cycle and stays 1 for exactly 16·(N+1) cycles.
- R3: When idle, a control write with bit 1 clear updates the select, loopback and divider settings and starts no transfer.
- R4: Select line n (n = 0, 1, 2) drives the level stored in control bit 2·n.
- R5: SCK idles low and MOSI idles at 0. During a transfer, each SCK high phase and each low phase lasts N+1 cycles, where N is control bits 31:27. MOSI changes on the falling edge and sends the byte MSB first.
- R6: The serial input is sampled on each rising SCK edge, MSB first. Once busy clears, a read at offset 0x4 returns the captured byte in bits 7:0, with bits 31:8 at zero. While idle, a data write stores bits 7:0 and a read returns them.
- R7: With control bit 3 set, the captured byte equals the byte sent, and the serial input pin has no effect.
- R8: While busy, a control write is ignored, with or without bit 1. The select lines, the divider and the transfer length stay unchanged, and no new transfer starts.
- R9: A control read returns the divider field in bits 31:27, the select bits in bits 0, 2 and 4, loopback in bit 3 and the live busy flag in bit 1. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset; bit 2 selects the data word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 3 | Select line levels |

## Verification
Several properties are checked on every cycle. The assertions confirm that SCK and MOSI rest low whenever no transfer runs, that a start write raises busy, and that a settings-only write leaves busy low. They also confirm that control writes during a transfer leave the select lines unchanged, and that reset brings back the all-high selects. Other behaviour shows only in the bench's end-to-end scenarios. These cover the bit order on the serial lines, the exact busy length and SCK high time for several divider values, and the returned byte for a full sweep of loopback patterns. They also show that a start write during a transfer neither restarts it nor changes the divider.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [2:0]        cs_line
);
  localparam int DIV_LSB = 27;
  localparam int PAD_W   = 32 - DIV_W;

  logic             busy, sck_q, loop_q;
  logic [2:0]       cs_q, bitn;
  logic [DIV_W-1:0] div_q, cnt;
  logic [7:0]       txsh, rxsh, data_q;

  wire sel_data = bus_addr[2];
  wire wr_ctrl  = bus_wr && !sel_data;
  wire wr_data  = bus_wr &&  sel_data;
  wire in_bit   = loop_q ? mosi : miso;
  wire tick     = (cnt == div_q);

  assign sck     = sck_q;
  assign mosi    = busy & txsh[7];
  assign cs_line = cs_q;

  wire [31:0] ctrl_word = ({{PAD_W{1'b0}}, div_q} << DIV_LSB)
                        | {27'd0, cs_q[2], loop_q, cs_q[1], busy, cs_q[0]};
  assign bus_rdata = sel_data ? {24'd0, data_q} : ctrl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 3'b111;
      loop_q <= 1'b0;
      div_q  <= '0;
      busy   <= 1'b0;
      sck_q  <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      txsh   <= '0;
      rxsh   <= '0;
      data_q <= '0;
    end else begin
      if (wr_ctrl && !busy) begin
        cs_q   <= {bus_wdata[4], bus_wdata[2], bus_wdata[0]};
        loop_q <= bus_wdata[3];
        div_q  <= bus_wdata[DIV_LSB +: DIV_W];
        if (bus_wdata[1]) begin
          busy  <= 1'b1;
          txsh  <= data_q;
          cnt   <= '0;
          bitn  <= '0;
          sck_q <= 1'b0;
        end
      end else if (wr_data && !busy) begin
        data_q <= bus_wdata[7:0];
      end
      if (busy) begin
        if (tick) begin
          cnt <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rxsh  <= {rxsh[6:0], in_bit};
          end else begin
            sck_q <= 1'b0;
            txsh  <= {txsh[6:0], 1'b0};
            if (bitn == 3'd7) begin
              busy   <= 1'b0;
              data_q <= rxsh;
            end else begin
              bitn <= bitn + 3'd1;
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (cs_line == 3'b111 && !busy && !sck && !mosi));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[1] && !busy) |=> busy);

  assert_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[1] && !busy) |=> !busy);

  assert_idle_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !mosi));

  assert_locked_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl) |=> $stable(cs_line));
endmodule

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, miso;
  logic [2:0]  cs_line;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] slv = 8'd0;
  logic [7:0] mcap = 8'd0;
  assign miso = slv[7];

  always #4 clk = ~clk;

  spi_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_line(cs_line)
  );

  always @(posedge sck) mcap <= {mcap[6:0], mosi};
  always @(negedge sck) slv  <= {slv[6:0], 1'b0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'h0;
  endtask

  function automatic logic [31:0] ctl(input int n, input logic [2:0] c,
                                      input logic lp, input logic go);
    return (32'(n) << 27) | {27'd0, c[2], lp, c[1], go, c[0]};
  endfunction

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sv, input int n,
                      input logic lp, input logic mid, input logic chk_all);
    int busy_cnt = 0;
    int hi_cnt = 0;
    logic [7:0] exp_rx;
    bwrite(4'h4, {24'hABCDEF, tx});
    slv = sv;
    mcap = 8'd0;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = ctl(n, 3'b101, lp, 1'b1);
    @(negedge clk);
    bus_wr = 1'b0;
    for (int it = 0; it < 4000; it++) begin
      if (bus_rdata[1] !== 1'b1) break;
      busy_cnt++;
      if (sck) hi_cnt++;
      if (mid && it == 3) begin
        bus_wr = 1'b1; bus_wdata = ctl(n + 1, 3'b010, ~lp, 1'b1);
      end else begin
        bus_wr = 1'b0;
      end
      @(negedge clk);
    end
    bus_wr = 1'b0;
    exp_rx = lp ? tx : sv;
    if (chk_all) begin
      check("R2 busy length", busy_cnt, 16 * (n + 1));
      check("R5 sck high cycles", hi_cnt, 8 * (n + 1));
      check("R5 mosi MSB-first byte", {24'd0, mcap}, {24'd0, tx});
    end
    bus_addr = 4'h4;
    #1;
    check(lp ? "R7 loopback byte" : "R6 captured byte", bus_rdata, {24'd0, exp_rx});
    bus_addr = 4'h0;
    if (mid) begin
      check("R8 busy length unchanged", busy_cnt, 16 * (n + 1));
      check("R8 cs unchanged", {29'd0, cs_line}, 32'd5);
      #1;
      check("R8 control unchanged", bus_rdata, ctl(n, 3'b101, lp, 1'b0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cs after reset", {29'd0, cs_line}, 32'd7);
    check("R1 sck/mosi low", {30'd0, sck, mosi}, 32'd0);
    check("R1 control read", bus_rdata, 32'h15);
    rst_n = 1'b1;
    @(negedge clk);

    bwrite(4'h0, ctl(2, 3'b001, 1'b1, 1'b0));
    repeat (3) @(negedge clk);
    check("R3 no transfer", {31'd0, bus_rdata[1]}, 32'd0);
    check("R9 control readback", bus_rdata, 32'h1000_0009);
    check("R3 cs updated", {29'd0, cs_line}, 32'd1);

    for (int c = 0; c < 8; c++) begin
      bwrite(4'h0, ctl(0, 3'(c), 1'b0, 1'b0));
      check("R4 cs mapping", {29'd0, cs_line}, 32'(c));
      check("R9 cs readback", bus_rdata, ctl(0, 3'(c), 1'b0, 1'b0));
    end

    bwrite(4'h4, 32'hFFFF_FF5A);
    bus_addr = 4'h4;
    #1;
    check("R6 data readback upper zero", bus_rdata, 32'h5A);
    bus_addr = 4'h0;

    for (int n = 0; n < 4; n++) begin
      xfer(8'hA5, 8'h3C, n, 1'b0, 1'b0, 1'b1);
      xfer(8'h81, 8'hC3, n, 1'b0, 1'b0, 1'b1);
      xfer(8'h00, 8'hFF, n, 1'b0, 1'b0, 1'b1);
    end

    for (int b = 0; b < 256; b++)
      xfer(8'(b), ~8'(b), 0, 1'b1, 1'b0, (b % 37) == 0);

    xfer(8'h6E, 8'h91, 1, 1'b0, 1'b1, 1'b1);
    xfer(8'h17, 8'hE8, 2, 1'b1, 1'b1, 1'b1);

    @(negedge clk);
    check("R5 idle lines", {30'd0, sck, mosi}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule